// File: doc/BRIEF.md
# Stop Mode Wakeup Sequencer

This block controls how a small processor core enters and leaves its lowest-power standby state. The instruction decoder sends a one-cycle stop strobe. If software has not disabled stopping, the sequencer asks the stacking datapath to save the register file, all except the stack pointer. It waits for that datapath to acknowledge. It then drops the system clock enable, so every register and pin holds its value.

While the system clock is off, the sequencer runs on a free-running always-on clock. It watches three level-sensitive wake sources: a reset request, a non-maskable-style interrupt line with its own mask bit, and a maskable interrupt line. On a wake it raises the clock enable again and tells the core how to go on, using a one-cycle resume pulse and a resume code. The core may take an interrupt vector, take the reset path, or continue in line. When the non-maskable line wakes the core while its mask is set, the core first runs a fixed instruction-queue recovery lasting a set number of cycles, and then continues in line.

Top module: `stop_wake_seq`

## Requirements
- R1: A stop strobe while `stop_dis` is 1 is ignored: `stack_req` stays 0 and `sys_clk_en` stays 1.
- R2: A stop strobe while `stop_dis` is 0 raises `stack_req` in the next cycle. `stack_req` stays high until `stack_ack` is seen, and `sys_clk_en` stays 1 while it waits.
- R3: The cycle after `stack_ack` is taken, `sys_clk_en` is 0. It stays 0 until a wake is accepted.
- R4: In standby, `wake_irq` does not wake the core while `mask_i` is 1. If `wake_irq` is held and `mask_i` is then cleared, the core wakes one cycle later.
- R5: `wake_rst` has priority over both interrupt lines. It gives resume code 3 (reset) with no queue recovery.
- R6: `wake_xirq` with `mask_x` = 0 gives resume code 1 (non-maskable vector fetch).
- R7: `wake_xirq` with `mask_x` = 1 holds `q_recov` high for exactly RECOV_CYCLES (default 2) cycles. The resume pulse with code 0 (next instruction) follows at once.
- R8: `wake_irq` with `mask_i` = 0 and no other wake gives resume code 2 (maskable vector fetch).
- R9: `wake_xirq` has priority over `wake_irq`, whether or not `mask_x` is set.
- R10: The resume pulse comes SYNC_STAGES+1 cycles after a wake input rises (default 3), plus RECOV_CYCLES when recovery runs. `sys_clk_en` is 1 throughout recovery and resume.
- R11: After reset, `stack_req`, `q_recov` and `resume_valid` are 0 and `sys_clk_en` is 1. `resume_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle stop strobe from the decoder |
| stop_dis | input | 1 | Stop disable bit; 1 turns the strobe into a no-op |
| mask_x | input | 1 | Non-maskable line mask bit |
| mask_i | input | 1 | Maskable interrupt mask bit |
| wake_rst | input | 1 | Reset wake request, level |
| wake_xirq | input | 1 | Non-maskable-style wake line, level |
| wake_irq | input | 1 | Maskable interrupt wake line, level |
| stack_ack | input | 1 | Stacking datapath done |
| stack_req | output | 1 | Request to stack the registers |
| sys_clk_en | output | 1 | System clock gate enable |
| q_recov | output | 1 | Instruction-queue recovery in progress |
| resume_valid | output | 1 | One-cycle resume pulse |
| resume_code | output | 2 | 0 next, 1 non-maskable vector, 2 maskable vector, 3 reset |

## Verification
Each stimulus has a fixed delay to its result. A stop strobe shows on `stack_req` one cycle later. An acknowledge drops `sys_clk_en` one cycle later. A wake input reaches the resume pulse three cycles later, or five when queue recovery runs. A mask cleared while its line is already synchronised takes effect one cycle later. When the driver applies a wake, it records the cycle in which the resume is due. The monitor compares the cycle number, the code and the length of the preceding recovery run at the falling edge, where outputs are stable.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [1:0] {
    RES_NEXT  = 2'd0,
    RES_XVEC  = 2'd1,
    RES_IVEC  = 2'd2,
    RES_RESET = 2'd3
  } resume_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STACK  = 3'd1,
    ST_STBY   = 3'd2,
    ST_RECOV  = 3'd3,
    ST_RESUME = 3'd4
  } seq_state_e;

endpackage

// File: rtl/stop_wake_sync.sv
module stop_wake_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
    end else begin : g_chain
      logic [WIDTH-1:0] pipe_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            pipe_q[s] <= '0;
          end else begin
            pipe_q[s] <= (s == 0) ? d_in : pipe_q[(s == 0) ? 0 : s-1];
          end
        end
      end
      assign d_out = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/stop_wake_arb.sv
module stop_wake_arb
  import stop_wake_pkg::*;
(
  input  logic    rst_s,
  input  logic    xirq_s,
  input  logic    irq_s,
  input  logic    mask_x,
  input  logic    mask_i,
  output logic    wake,
  output logic    need_recov,
  output resume_e wake_code
);

  always_comb begin
    wake       = 1'b0;
    need_recov = 1'b0;
    wake_code  = RES_NEXT;
    if (rst_s) begin
      wake      = 1'b1;
      wake_code = RES_RESET;
    end else if (xirq_s) begin
      wake = 1'b1;
      if (mask_x) begin
        need_recov = 1'b1;
        wake_code  = RES_NEXT;
      end else begin
        wake_code = RES_XVEC;
      end
    end else if (irq_s && !mask_i) begin
      wake      = 1'b1;
      wake_code = RES_IVEC;
    end
  end

endmodule

// File: rtl/stop_wake_fsm.sv
module stop_wake_fsm
  import stop_wake_pkg::*;
#(
  parameter int RECOV_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       stop_dis,
  input  logic       stack_ack,
  input  logic       wake,
  input  logic       need_recov,
  input  resume_e    wake_code,
  output logic       stack_req,
  output logic       sys_clk_en,
  output logic       q_recov,
  output logic       resume_valid,
  output logic [1:0] resume_code
);

  localparam int CW = (RECOV_CYCLES > 1) ? $clog2(RECOV_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(RECOV_CYCLES - 1);

  seq_state_e state_q, state_nxt;
  resume_e    code_q, code_nxt;
  logic       code_en;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic       cnt_en;

  always_comb begin
    state_nxt = state_q;
    code_nxt  = code_q;
    code_en   = 1'b0;
    cnt_nxt   = cnt_q;
    cnt_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (stop_req && !stop_dis) state_nxt = ST_STACK;
      end
      ST_STACK: begin
        if (stack_ack) state_nxt = ST_STBY;
      end
      ST_STBY: begin
        if (wake) begin
          if (need_recov) begin
            state_nxt = ST_RECOV;
            cnt_nxt   = '0;
            cnt_en    = 1'b1;
          end else begin
            state_nxt = ST_RESUME;
            code_nxt  = wake_code;
            code_en   = 1'b1;
          end
        end
      end
      ST_RECOV: begin
        if (cnt_q == CNT_LAST) begin
          state_nxt = ST_RESUME;
          code_nxt  = RES_NEXT;
          code_en   = 1'b1;
        end else begin
          cnt_nxt = CW'(cnt_q + 1'b1);
          cnt_en  = 1'b1;
        end
      end
      ST_RESUME: begin
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RES_NEXT;
    end else if (code_en) begin
      code_q <= code_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign stack_req    = (state_q == ST_STACK);
  assign sys_clk_en   = (state_q != ST_STBY);
  assign q_recov      = (state_q == ST_RECOV);
  assign resume_valid = (state_q == ST_RESUME);
  assign resume_code  = code_q;

endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import stop_wake_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RECOV_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       stop_dis,
  input  logic       mask_x,
  input  logic       mask_i,
  input  logic       wake_rst,
  input  logic       wake_xirq,
  input  logic       wake_irq,
  input  logic       stack_ack,
  output logic       stack_req,
  output logic       sys_clk_en,
  output logic       q_recov,
  output logic       resume_valid,
  output logic [1:0] resume_code
);

  localparam int NWAKE = 3;

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  logic [NWAKE-1:0] wake_raw, wake_s;
  assign wake_raw = {wake_irq, wake_xirq, wake_rst};

  stop_wake_sync #(
    .WIDTH  (NWAKE),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_in  (wake_raw),
    .d_out (wake_s)
  );

  logic    wake, need_recov;
  resume_e wake_code;

  stop_wake_arb u_arb (
    .rst_s      (wake_s[0]),
    .xirq_s     (wake_s[1]),
    .irq_s      (wake_s[2]),
    .mask_x     (mask_x),
    .mask_i     (mask_i),
    .wake       (wake),
    .need_recov (need_recov),
    .wake_code  (wake_code)
  );

  stop_wake_fsm #(
    .RECOV_CYCLES (RECOV_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .stop_req     (stop_req),
    .stop_dis     (stop_dis),
    .stack_ack    (stack_ack),
    .wake         (wake),
    .need_recov   (need_recov),
    .wake_code    (wake_code),
    .stack_req    (stack_req),
    .sys_clk_en   (sys_clk_en),
    .q_recov      (q_recov),
    .resume_valid (resume_valid),
    .resume_code  (resume_code)
  );

endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_req,
  input logic       stop_dis,
  input logic       stack_ack,
  input logic       stack_req,
  input logic       sys_clk_en,
  input logic       q_recov,
  input logic       resume_valid,
  input logic [1:0] resume_code
);

  // R1
  stop_dis_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_clk_en && !stack_req && !q_recov && !resume_valid && stop_req && stop_dis)
      |=> !stack_req);

  // R2
  stack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_req && !stack_ack) |=> (stack_req && sys_clk_en));

  // R3
  gate_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_req && stack_ack) |=> !sys_clk_en);

  // R7
  recov_then_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_recov) |-> (resume_valid && resume_code == 2'd0));

  // R5
  reset_no_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_valid && resume_code == 2'd3) |-> !$past(q_recov));

  // R10
  clk_on_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_recov || resume_valid) |-> sys_clk_en);

  // R11
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |=> !resume_valid);

endmodule

bind stop_wake_seq stop_wake_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_req     (stop_req),
  .stop_dis     (stop_dis),
  .stack_ack    (stack_ack),
  .stack_req    (stack_req),
  .sys_clk_en   (sys_clk_en),
  .q_recov      (q_recov),
  .resume_valid (resume_valid),
  .resume_code  (resume_code)
);

// File: tb/stop_wake_seq_tb_top.sv
module stop_wake_seq_tb_top;

  localparam int SYNC = 2;
  localparam int RECOV = 2;
  localparam int LAT = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, stop_dis = 1'b0, mask_x = 1'b0, mask_i = 1'b0;
  logic wake_rst = 1'b0, wake_xirq = 1'b0, wake_irq = 1'b0, stack_ack = 1'b0;
  logic stack_req, sys_clk_en, q_recov, resume_valid;
  logic [1:0] resume_code;

  always #10 clk = ~clk;

  stop_wake_seq #(.SYNC_STAGES(SYNC), .RECOV_CYCLES(RECOV)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_dis(stop_dis),
    .mask_x(mask_x), .mask_i(mask_i), .wake_rst(wake_rst),
    .wake_xirq(wake_xirq), .wake_irq(wake_irq), .stack_ack(stack_ack),
    .stack_req(stack_req), .sys_clk_en(sys_clk_en), .q_recov(q_recov),
    .resume_valid(resume_valid), .resume_code(resume_code)
  );

  typedef struct {
    logic [1:0] code;
    int         due;
    int         recov;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   cyc     = 0;
  int   rec_run = 0;
  bit   mon_on  = 1'b0;
  bit   done    = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops the scoreboard on every resume pulse
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_recov) begin
        check(sys_clk_en == 1'b1, "R10 clk_en during recovery", int'(sys_clk_en), 1);
        rec_run++;
      end
      if (resume_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected resume", int'(resume_code), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(resume_code == e.code, {e.tag, " code"}, int'(resume_code), int'(e.code));
          check(cyc == e.due, "R10 resume cycle", cyc, e.due);
          check(rec_run == e.recov, "R7 recovery length", rec_run, e.recov);
          check(sys_clk_en == 1'b1, "R10 clk_en at resume", int'(sys_clk_en), 1);
        end
        rec_run = 0;
      end
    end
  end

  task automatic enter_standby();
    stop_dis = 1'b0;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check(stack_req == 1'b1, "R2 stack_req raised", int'(stack_req), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(stack_req == 1'b1 && sys_clk_en == 1'b1, "R2 wait for ack",
            int'({stack_req, sys_clk_en}), 3);
    end
    stack_ack = 1'b1;
    @(negedge clk);
    stack_ack = 1'b0;
    check(sys_clk_en == 1'b0, "R3 clock gated", int'(sys_clk_en), 0);
    check(stack_req == 1'b0, "R3 stack_req dropped", int'(stack_req), 0);
  endtask

  task automatic do_wake(input logic r, input logic x, input logic i,
                         input logic mx, input logic mi,
                         input logic [1:0] code, input int lat, input int rc,
                         input string tag);
    exp_t e;
    mask_x = mx;
    mask_i = mi;
    e.code = code; e.due = cyc + lat; e.recov = rc; e.tag = tag;
    exp_q.push_back(e);
    wake_rst = r; wake_xirq = x; wake_irq = i;
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, {tag, " resume seen"}, exp_q.size(), 0);
    exp_q.delete();
    wake_rst = 1'b0; wake_xirq = 1'b0; wake_irq = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(stack_req == 1'b0, "R11 reset stack_req", int'(stack_req), 0);
    check(sys_clk_en == 1'b1, "R11 reset clk_en", int'(sys_clk_en), 1);
    check(q_recov == 1'b0, "R11 reset q_recov", int'(q_recov), 0);
    check(resume_valid == 1'b0, "R11 reset resume", int'(resume_valid), 0);
    mon_on = 1'b1;

    // R1 disabled stop is a no-op
    stop_dis = 1'b1;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(stack_req == 1'b0 && sys_clk_en == 1'b1, "R1 stop ignored",
            int'({stack_req, sys_clk_en}), 1);
      @(negedge clk);
    end

    // R6 unmasked non-maskable line
    enter_standby();
    do_wake(0, 1, 0, 0, 1, 2'd1, LAT, 0, "R6");

    // R7 masked non-maskable line: recovery then next instruction
    enter_standby();
    do_wake(0, 1, 0, 1, 1, 2'd0, LAT + RECOV, RECOV, "R7");

    // R8 maskable interrupt
    enter_standby();
    do_wake(0, 0, 1, 1, 0, 2'd2, LAT, 0, "R8");

    // R5 reset beats everything
    enter_standby();
    do_wake(1, 1, 1, 1, 0, 2'd3, LAT, 0, "R5");

    // R9 non-maskable beats maskable, both mask settings
    enter_standby();
    do_wake(0, 1, 1, 0, 0, 2'd1, LAT, 0, "R9 unmasked");
    enter_standby();
    do_wake(0, 1, 1, 1, 0, 2'd0, LAT + RECOV, RECOV, "R9 masked");

    // R4 masked interrupt does not wake; clearing the mask then wakes in one cycle
    enter_standby();
    mask_i = 1'b1;
    wake_irq = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(sys_clk_en == 1'b0 && resume_valid == 1'b0, "R4 stays in standby",
            int'({sys_clk_en, resume_valid}), 0);
    end
    do_wake(0, 0, 1, 1, 0, 2'd2, 1, 0, "R4 mask cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule